// File: doc/BRIEF.md
# ADC Offset and Gain Calibration Sequencer

The block drives a hardware calibration of an analog-to-digital converter and then corrects every ordinary conversion with the two coefficients that the calibration produced. When a start strobe arrives, the block asks the converter for one reading of a ground input and keeps that reading as the offset coefficient. It then asks for one reading of a reference input and divides full scale by the span between the two readings. A sequential divider does this division, which gives the gain coefficient.

Two modes set which inputs are read. Device mode uses fixed internal channel codes. System mode uses two channel numbers supplied by the user, one wired to system ground and one wired to the system reference. Software can also write or read either coefficient through a small byte-wide register port. Each 14-bit coefficient is split into an 8-bit low byte and a 6-bit high byte. Any conversion the converter delivers while the block is idle is corrected with the current coefficients and presented one cycle later.

Top module: `adc_cal_seq`

## Requirements
- R1: After reset the offset coefficient is 0, the gain coefficient is 0x2000 (unity), and done_o, busy_o and adc_req_o are low.
- R2: Register addresses are: 0 = offset bits 7:0, 1 = offset bits 13:8 (6 bits), 2 = gain bits 7:0, 3 = gain bits 13:8 (6 bits). A write updates only the addressed half. The upper two bits of a high half always read back as zero.
- R3: In device mode the ground reading uses channel code 4'b1011 and the reference reading uses channel code 4'b1100.
- R4: In system mode the ground reading uses the channel on sys_gnd_ch_i and the reference reading uses the channel on sys_ref_ch_i, both sampled with the start strobe.
- R5: The ground (offset) request is always issued and acknowledged before the reference (gain) request. A calibration makes exactly two requests. adc_req_o and adc_ch_o hold steady until adc_ack_i.
- R6: The offset coefficient becomes the raw ground reading.
- R7: The gain becomes floor(4095*8192 / (ref - offset)), clamped to the range 7992..8402. If ref <= offset, the gain becomes 8402.
- R8: When adc_ack_i arrives while busy_o is low, corr_valid_o pulses in the next cycle. At the same time corr_o = min(4095, floor(max(0, raw - offset) * gain / 8192)).
- R9: busy_o is high from the cycle after an accepted start until done_o. done_o is a single-cycle pulse, raised once per calibration after both coefficients have been updated.
- R10: A register write changes the coefficient used by the next correction.
- R11: A start strobe that arrives while busy_o is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Calibration start strobe |
| sys_mode_i | input | 1 | 1 = system mode, 0 = device mode |
| sys_gnd_ch_i | input | 4 | Ground channel used in system mode |
| sys_ref_ch_i | input | 4 | Reference channel used in system mode |
| adc_req_o | output | 1 | Conversion request, held until acknowledged |
| adc_ch_o | output | 4 | Channel to convert |
| adc_ack_i | input | 1 | Conversion result valid |
| adc_raw_i | input | 12 | Raw conversion result |
| reg_we_i | input | 1 | Coefficient register write enable |
| reg_addr_i | input | 2 | Coefficient register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| ofs_o | output | 14 | Current offset coefficient |
| gain_o | output | 14 | Current gain coefficient |
| corr_o | output | 12 | Corrected conversion |
| corr_valid_o | output | 1 | corr_o is valid |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | Calibration finished pulse |

## Verification
The bench pushes the correction into both clamps. A raw value below the offset must give zero, not a wrapped large number. A large gain must saturate at 4095 and not drop the upper bits. It runs calibrations whose span falls inside, above and below the gain window, including a reference at or below the ground reading. A design that skips the clamp or divides by zero will leave a wrong gain_o at done_o. A second start is fired in the middle of a calibration. A design that restarts on it makes extra requests or a second done pulse. The bench also records the order of the channel codes. A swapped sequence or a wrong device code shows up directly.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  localparam logic [3:0] CH_INT_GND = 4'b1011;
  localparam logic [3:0] CH_INT_REF = 4'b1100;

  typedef enum logic [1:0] {
    A_OFS_LO  = 2'd0,
    A_OFS_HI  = 2'd1,
    A_GAIN_LO = 2'd2,
    A_GAIN_HI = 2'd3
  } reg_addr_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_OFS,
    S_REF,
    S_DIV,
    S_FIN
  } cal_state_e;
endpackage

// File: rtl/adc_cal_div.sv
module adc_cal_div #(
  parameter int NUM_W = 25,
  parameter int DEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic             done_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [DEN_W:0]   rem_sh;
  logic             ge;

  assign rem_sh = {rem_q, q_q[NUM_W-1]};
  assign ge     = rem_sh >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        q_q   <= num_i;
        rem_q <= '0;
        den_q <= den_i;
        cnt_q <= CNT_W'(NUM_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        q_q   <= {q_q[NUM_W-2:0], ge};
        rem_q <= ge ? DEN_W'(rem_sh - {1'b0, den_q}) : rem_sh[DEN_W-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = q_q;
endmodule

// File: rtl/adc_cal_corr.sv
module adc_cal_corr #(
  parameter int RAW_W  = 12,
  parameter int COEF_W = 14,
  parameter int FRAC_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [RAW_W-1:0]  raw_i,
  input  logic [COEF_W-1:0] ofs_i,
  input  logic [COEF_W-1:0] gain_i,
  output logic [RAW_W-1:0]  corr_o,
  output logic              vld_o
);
  localparam int PROD_W = RAW_W + COEF_W;
  localparam int SCL_W  = PROD_W - FRAC_W;

  logic              below;
  logic [RAW_W-1:0]  mag;
  logic [PROD_W-1:0] prod;
  logic [SCL_W-1:0]  scaled;
  logic [RAW_W-1:0]  res;

  assign below  = {{(COEF_W-RAW_W){1'b0}}, raw_i} < ofs_i;
  assign mag    = below ? '0 : raw_i - ofs_i[RAW_W-1:0];
  assign prod   = {{COEF_W{1'b0}}, mag} * {{RAW_W{1'b0}}, gain_i};
  assign scaled = prod[PROD_W-1:FRAC_W];
  assign res    = (|scaled[SCL_W-1:RAW_W]) ? '1 : scaled[RAW_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      corr_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) corr_o <= res;
    end
  end
endmodule

// File: rtl/adc_cal_regs.sv
module adc_cal_regs
  import adc_cal_pkg::*;
#(
  parameter int COEF_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              cal_ofs_we_i,
  input  logic [COEF_W-1:0] cal_ofs_i,
  input  logic              cal_gain_we_i,
  input  logic [COEF_W-1:0] cal_gain_i,
  output logic [COEF_W-1:0] ofs_o,
  output logic [COEF_W-1:0] gain_o,
  output logic [7:0]        rdata_o
);
  localparam int HI_W = COEF_W - 8;
  localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << (COEF_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_o  <= '0;
      gain_o <= UNITY;
    end else begin
      if (cal_ofs_we_i) ofs_o <= cal_ofs_i;
      else if (we_i && addr_i == A_OFS_LO) ofs_o[7:0] <= wdata_i;
      else if (we_i && addr_i == A_OFS_HI) ofs_o[COEF_W-1:8] <= wdata_i[HI_W-1:0];
      if (cal_gain_we_i) gain_o <= cal_gain_i;
      else if (we_i && addr_i == A_GAIN_LO) gain_o[7:0] <= wdata_i;
      else if (we_i && addr_i == A_GAIN_HI) gain_o[COEF_W-1:8] <= wdata_i[HI_W-1:0];
    end
  end

  always_comb begin
    unique case (addr_i)
      A_OFS_LO:  rdata_o = ofs_o[7:0];
      A_OFS_HI:  rdata_o = 8'(ofs_o[COEF_W-1:8]);
      A_GAIN_LO: rdata_o = gain_o[7:0];
      default:   rdata_o = 8'(gain_o[COEF_W-1:8]);
    endcase
  end
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
  import adc_cal_pkg::*;
#(
  parameter int RAW_W  = 12,
  parameter int COEF_W = 14,
  parameter int CH_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sys_mode_i,
  input  logic [CH_W-1:0]   sys_gnd_ch_i,
  input  logic [CH_W-1:0]   sys_ref_ch_i,
  output logic              adc_req_o,
  output logic [CH_W-1:0]   adc_ch_o,
  input  logic              adc_ack_i,
  input  logic [RAW_W-1:0]  adc_raw_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic [COEF_W-1:0] ofs_o,
  output logic [COEF_W-1:0] gain_o,
  output logic [RAW_W-1:0]  corr_o,
  output logic              corr_valid_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int FRAC_W = COEF_W - 1;
  localparam int NUM_W  = RAW_W + FRAC_W;
  localparam logic [NUM_W-1:0] FULL_NUM = NUM_W'((2 ** RAW_W) - 1) << FRAC_W;
  localparam int UNITY    = 2 ** FRAC_W;
  localparam int GAIN_MIN = (UNITY * 40) / 41;  // span 1.025 x ref
  localparam int GAIN_MAX = (UNITY * 40) / 39;  // span 0.975 x ref

  cal_state_e       state_q;
  logic             sys_q;
  logic [CH_W-1:0]  gnd_ch_q, ref_ch_q;
  logic             cal_ofs_we, cal_gain_we, div_start, div_done;
  logic [COEF_W-1:0] cal_gain;
  logic [NUM_W-1:0] quo;
  logic [RAW_W-1:0] den;
  logic             ref_low;

  assign ref_low = {{(COEF_W-RAW_W){1'b0}}, adc_raw_i} <= ofs_o;
  assign den     = adc_raw_i - ofs_o[RAW_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      sys_q    <= 1'b0;
      gnd_ch_q <= '0;
      ref_ch_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q  <= S_OFS;
          sys_q    <= sys_mode_i;
          gnd_ch_q <= sys_mode_i ? sys_gnd_ch_i : CH_W'(CH_INT_GND);
          ref_ch_q <= sys_mode_i ? sys_ref_ch_i : CH_W'(CH_INT_REF);
        end
        S_OFS:  if (adc_ack_i) state_q <= S_REF;
        S_REF:  if (adc_ack_i) state_q <= ref_low ? S_FIN : S_DIV;
        S_DIV:  if (div_done) state_q <= S_FIN;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cal_ofs_we  = state_q == S_OFS && adc_ack_i;
    div_start   = state_q == S_REF && adc_ack_i && !ref_low;
    cal_gain_we = (state_q == S_REF && adc_ack_i && ref_low) || (state_q == S_DIV && div_done);
    if (state_q == S_REF)         cal_gain = COEF_W'(GAIN_MAX);
    else if (quo > NUM_W'(GAIN_MAX)) cal_gain = COEF_W'(GAIN_MAX);
    else if (quo < NUM_W'(GAIN_MIN)) cal_gain = COEF_W'(GAIN_MIN);
    else                          cal_gain = quo[COEF_W-1:0];
  end

  assign adc_req_o = state_q == S_OFS || state_q == S_REF;
  assign adc_ch_o  = state_q == S_OFS ? gnd_ch_q : (state_q == S_REF ? ref_ch_q : '0);
  assign busy_o    = state_q != S_IDLE;
  assign done_o    = state_q == S_FIN;

  adc_cal_div #(.NUM_W(NUM_W), .DEN_W(RAW_W)) u_div (
    .clk_i, .rst_ni, .start_i(div_start), .num_i(FULL_NUM), .den_i(den),
    .quo_o(quo), .done_o(div_done)
  );

  adc_cal_regs #(.COEF_W(COEF_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cal_ofs_we_i(cal_ofs_we), .cal_ofs_i(COEF_W'(adc_raw_i)),
    .cal_gain_we_i(cal_gain_we), .cal_gain_i(cal_gain),
    .ofs_o, .gain_o, .rdata_o(reg_rdata_o)
  );

  adc_cal_corr #(.RAW_W(RAW_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_corr (
    .clk_i, .rst_ni, .vld_i(adc_ack_i && !busy_o), .raw_i(adc_raw_i),
    .ofs_i(ofs_o), .gain_i(gain_o), .corr_o, .vld_o(corr_valid_o)
  );
endmodule

// File: rtl/adc_cal_chk.sv
module adc_cal_chk
  import adc_cal_pkg::*;
#(
  parameter int COEF_W = 14,
  parameter int CH_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adc_req_o,
  input logic [CH_W-1:0]   adc_ch_o,
  input logic              adc_ack_i,
  input logic              reg_we_i,
  input logic [COEF_W-1:0] gain_o,
  input logic              corr_valid_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              sys_q
);
  localparam int UNITY = 2 ** (COEF_W - 1);

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_no_req_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !adc_req_o);
  a_r5_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_o && !adc_ack_i |=> adc_req_o && $stable(adc_ch_o));
  a_r3_dev_codes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_o && !sys_q |-> (adc_ch_o == CH_W'(CH_INT_GND) || adc_ch_o == CH_W'(CH_INT_REF)));
  a_r8_valid_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_valid_o |-> $past(adc_ack_i) && !$past(busy_o));
  a_r7_gain_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !$past(reg_we_i) |->
      gain_o >= COEF_W'((UNITY * 40) / 41) && gain_o <= COEF_W'((UNITY * 40) / 39));
endmodule

bind adc_cal_seq adc_cal_chk #(.COEF_W(COEF_W), .CH_W(CH_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .adc_req_o(adc_req_o), .adc_ch_o(adc_ch_o),
  .adc_ack_i(adc_ack_i), .reg_we_i(reg_we_i), .gain_o(gain_o),
  .corr_valid_o(corr_valid_o), .busy_o(busy_o), .done_o(done_o), .sys_q(sys_q)
);

// File: tb/adc_cal_seq_bench.sv
`timescale 1ns/1ps
module adc_cal_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start = 0, sys_mode = 0;
  logic [3:0] gnd_ch = 0, ref_ch = 0;
  logic adc_req, adc_ack, corr_valid, busy, done;
  logic [3:0] adc_ch;
  logic [11:0] adc_raw, corr;
  logic we = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [13:0] ofs, gain;

  logic model_ack = 0, dir_ack = 0;
  logic [11:0] model_raw = 0, dir_raw = 0;
  assign adc_ack = model_ack | dir_ack;
  assign adc_raw = model_ack ? model_raw : dir_raw;

  adc_cal_seq u_adc_cal_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sys_mode_i(sys_mode),
    .sys_gnd_ch_i(gnd_ch), .sys_ref_ch_i(ref_ch), .adc_req_o(adc_req), .adc_ch_o(adc_ch),
    .adc_ack_i(adc_ack), .adc_raw_i(adc_raw), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ofs_o(ofs), .gain_o(gain),
    .corr_o(corr), .corr_valid_o(corr_valid), .busy_o(busy), .done_o(done)
  );

  int total = 0, bad = 0, done_cnt = 0, ch_cnt = 0, dly = 0;
  logic [3:0] ch_log [4];
  logic [3:0] exp_gnd_ch, exp_ref_ch;
  logic [11:0] gnd_val, ref_val;
  bit finished = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_corr(int raw, int o, int g);
    int m, r;
    m = (raw < o) ? 0 : raw - o;
    r = (m * g) / 8192;
    return (r > 4095) ? 4095 : r;
  endfunction

  function automatic int exp_gain(int r, int o);
    int q;
    if (r <= o) return 8402;
    q = (4095 * 8192) / (r - o);
    if (q > 8402) q = 8402;
    if (q < 7992) q = 7992;
    return q;
  endfunction

  // converter model
  always @(negedge clk) begin
    if (done) done_cnt <= done_cnt + 1;
    model_ack <= 1'b0;
    if (adc_req && !model_ack) begin
      if (dly == 0) begin
        model_ack <= 1'b1;
        model_raw <= (adc_ch == exp_gnd_ch) ? gnd_val : (adc_ch == exp_ref_ch) ? ref_val : 12'hABC;
        if (ch_cnt < 4) ch_log[ch_cnt] <= adc_ch;
        ch_cnt <= ch_cnt + 1;
        dly <= 2;
      end else dly <= dly - 1;
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic conv(logic [11:0] raw, string req);
    int e;
    e = exp_corr(raw, ofs, gain);
    @(negedge clk); dir_ack = 1; dir_raw = raw;
    @(negedge clk); dir_ack = 0;
    chk({req, " valid"}, corr_valid, 1);
    chk({req, " corr"}, corr, e);
  endtask

  task automatic run_cal(bit mode, logic [3:0] g, logic [3:0] r, logic [11:0] gv, logic [11:0] rv,
                         bit restart);
    int d0, eg;
    @(negedge clk);
    exp_gnd_ch = mode ? g : 4'b1011;
    exp_ref_ch = mode ? r : 4'b1100;
    gnd_val = gv; ref_val = rv; ch_cnt = 0; d0 = done_cnt;
    start = 1; sys_mode = mode; gnd_ch = g; ref_ch = r;
    @(negedge clk); start = 0; sys_mode = ~mode; gnd_ch = ~g; ref_ch = ~r;
    chk("R9 busy after start", busy, 1);
    if (restart) begin
      repeat (4) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    for (int i = 0; i < 400 && done_cnt == d0; i++) @(negedge clk);
    eg = exp_gain(rv, gv);
    chk("R6 offset", ofs, gv);
    chk("R7 gain", gain, eg);
    repeat (6) @(negedge clk);
    chk("R9 one done", done_cnt - d0, 1);
    chk("R5 two requests", ch_cnt, 2);
    chk(mode ? "R4 gnd ch" : "R3 gnd ch", ch_log[0], exp_gnd_ch);
    chk(mode ? "R4 ref ch" : "R3 ref ch", ch_log[1], exp_ref_ch);
    chk("R11 idle after", busy, 0);
    chk("R11 no req", adc_req, 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ofs", ofs, 0);
    chk("R1 gain", gain, 'h2000);
    chk("R1 done", done, 0);
    chk("R1 busy", busy, 0);
    chk("R1 req", adc_req, 0);
    addr = 2'd3; #0.1; chk("R2 gain hi read", rdata, 8'h20);
    conv(12'd1000, "R8 unity");
    conv(12'd4095, "R8 unity max");
    // R2 and R10 register halves
    wr(2'd0, 8'h34); wr(2'd1, 8'hFF);
    chk("R2 ofs half write", ofs, 14'h3F34);
    addr = 2'd1; #0.1; chk("R2 ofs hi read", rdata, 8'h3F);
    addr = 2'd0; #0.1; chk("R2 ofs lo read", rdata, 8'h34);
    conv(12'd4000, "R8 below offset");
    wr(2'd1, 8'h00); wr(2'd0, 8'd100);
    chk("R10 ofs", ofs, 100);
    conv(12'd100, "R10 zero");
    conv(12'd99, "R8 clamp low");
    wr(2'd3, 8'h3F); wr(2'd2, 8'hFF);
    addr = 2'd2; #0.1; chk("R2 gain lo read", rdata, 8'hFF);
    conv(12'd3000, "R8 clamp high");
    wr(2'd3, 8'h20); wr(2'd2, 8'h00);
    conv(12'd2100, "R10 gain");
    // calibrations
    run_cal(0, 4'd0, 4'd0, 12'd37, 12'd4060, 0);
    conv(12'd2000, "R8 after dev cal");
    run_cal(1, 4'd3, 4'd7, 12'd100, 12'd3900, 0);
    run_cal(1, 4'd5, 4'd2, 12'd10, 12'd4095, 1);
    run_cal(0, 4'd0, 4'd0, 12'd500, 12'd400, 0);
    run_cal(1, 4'd9, 4'd9, 12'd7, 12'd9, 0);
    for (int n = 0; n < 12; n++) begin
      int gv, rv;
      logic [3:0] g, r;
      gv = $urandom_range(0, 80);
      rv = gv + $urandom_range(3950, 4015);
      if (rv > 4095) rv = 4095;
      g = 4'($urandom_range(0, 7));
      r = 4'($urandom_range(8, 15));
      run_cal(n[0], g, r, 12'(gv), 12'(rv), n % 3 == 0);
      for (int k = 0; k < 6; k++) conv(12'($urandom_range(0, 4095)), "R8 random");
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule